// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of token latches shared by two independent ports, called left and right. Each port selects a token with the low bits of its address and either writes it or reads it. Writing 0 on data bit 0 asks for the token. Writing 1 gives the token back or drops a request that has not yet been granted. Reading returns a port-relative view: 0 means the reading port holds the token, and 1 means it does not.

If a request arrives while the opposite side holds the token, the request is remembered. It is granted on the same clock edge at which the holder lets go. When both ports request the same free token in the same cycle, the left port wins by default and the right request is remembered as waiting. A parameter can flip that priority.

All state is synchronous to one clock. Write effects appear at the next edge. Read data lands in a per-port output register one cycle after the read strobe and then holds still.

Top module: `sem_bank`

## Requirements
- R1: The bank holds NUM_SEM tokens (default 8). A token is picked by the low log2(NUM_SEM) address bits, and the higher address bits have no effect.
- R2: A port accesses a token only when its token select is low and its chip enable is high. Write strobe low means write and high means read. Select high, or select and chip enable both low, changes no token and no read register.
- R3: A free token reads 1 on both ports. After port P writes 0 to a free token, P reads 0 and the other port reads 1.
- R4: A write of 0 from the non-holder never takes the token away from the holder. Instead it records a waiting request.
- R5: When the holder writes 1 while a request is waiting, the token passes to the other side at that same clock edge.
- R6: A write of 1 from the non-holder withdraws its waiting request. A later release by the holder then leaves the token free.
- R7: A read drives the token view onto every one of the DATA_W data output lines, so each read word is all zeros or all ones.
- R8: Read data is registered. It appears the cycle after the read, reflects the state before any write at that same edge, and holds until the same port reads again.
- R9: When both ports write 0 to the same free token in one cycle, the left port gets the token and the right request becomes waiting (LEFT_FIRST=1).
- R10: A synchronous reset frees every token, clears every waiting request and sets both read registers to all ones.
- R11: On writes only data bit 0 matters. The other data bits have no effect.
- R12: A write of 0 by the current holder leaves the token and any waiting request unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_tok_sel_n | input | 1 | Left token select, active low |
| l_chip_en_n | input | 1 | Left memory enable, active low; must be high for token access |
| l_wr_n | input | 1 | Left write strobe, low = write, high = read |
| l_addr | input | ADDR_W | Left address; low bits pick the token |
| l_wdata | input | DATA_W | Left write data; bit 0 used |
| l_rdata | output | DATA_W | Left registered read data |
| r_tok_sel_n | input | 1 | Right token select, active low |
| r_chip_en_n | input | 1 | Right memory enable, active low; must be high for token access |
| r_wr_n | input | 1 | Right write strobe, low = write, high = read |
| r_addr | input | ADDR_W | Right address; low bits pick the token |
| r_wdata | input | DATA_W | Right write data; bit 0 used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
The assertions assume that every strobe, address and data input is synchronous to the clock and settled at each rising edge. Each level seen at an edge counts as exactly one access; an asynchronous strobe pulse is never assumed. The bench meets this by changing every input only on falling edges. It holds each operation for exactly one cycle, so a held write is never counted twice by mistake. The sweep covers idle, read, write and the illegal select-plus-enable combination on both ports at once, including same-token collisions. Junk in the upper address and data bits is varied so that R1 and R11 are exercised on every access.

// File: rtl/sem_bank_pkg.sv
package sem_bank_pkg;

   // Who holds a token. Encoding 3 is unused and reads as free.
   typedef enum logic [1:0] {
      TK_FREE  = 2'd0,
      TK_LEFT  = 2'd1,
      TK_RIGHT = 2'd2
   } tok_own_e;

   typedef struct packed {
      tok_own_e own;   // current holder
      logic     wait_q; // non-holder has an outstanding request
   } tok_state_t;

   localparam tok_state_t TOK_RESET = '{own: TK_FREE, wait_q: 1'b0};

   // One write applied to one token state.
   // from_right selects the writing side; rel is data bit 0 (1 = give back).
   function automatic tok_state_t tok_step(tok_state_t s, logic from_right, logic rel);
      tok_state_t n;
      tok_own_e   mine;
      tok_own_e   theirs;
      n      = s;
      mine   = from_right ? TK_RIGHT : TK_LEFT;
      theirs = from_right ? TK_LEFT  : TK_RIGHT;
      if (s.own == mine) begin
         if (rel) begin
            n.own    = s.wait_q ? theirs : TK_FREE;
            n.wait_q = 1'b0;
         end
      end else if (s.own == theirs) begin
         n.wait_q = ~rel;
      end else begin
         if (!rel) begin
            n.own    = mine;
            n.wait_q = 1'b0;
         end else begin
            n = TOK_RESET;
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/sem_cell.sv
module sem_cell
   import sem_bank_pkg::*;
#(
   parameter bit LEFT_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic l_we,
   input  logic l_rel,
   input  logic r_we,
   input  logic r_rel,
   output logic l_held,
   output logic r_held
);

   tok_state_t cur_q;
   tok_state_t mid;
   tok_state_t nxt;

   // Same-cycle writes are applied one after the other; the first one wins ties.
   generate
      if (LEFT_FIRST) begin : g_left_first
         assign mid = l_we ? tok_step(cur_q, 1'b0, l_rel) : cur_q;
         assign nxt = r_we ? tok_step(mid,   1'b1, r_rel) : mid;
      end else begin : g_right_first
         assign mid = r_we ? tok_step(cur_q, 1'b1, r_rel) : cur_q;
         assign nxt = l_we ? tok_step(mid,   1'b0, l_rel) : mid;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) cur_q <= TOK_RESET;
      else     cur_q <= nxt;
   end

   assign l_held = (cur_q.own == TK_LEFT);
   assign r_held = (cur_q.own == TK_RIGHT);

endmodule

// File: rtl/sem_port.sv
module sem_port #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 9
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tok_sel_n,
   input  logic               chip_en_n,
   input  logic               wr_n,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   input  logic [NUM_SEM-1:0] held_vec,
   output logic [NUM_SEM-1:0] we_vec,
   output logic               rel,
   output logic [DATA_W-1:0]  rdata
);

   localparam int IDX_W = $clog2(NUM_SEM);

   logic             access;
   logic             do_wr;
   logic             do_rd;
   logic [IDX_W-1:0] idx;

   // Token access needs select low and memory enable high; both low is illegal.
   assign access = ~tok_sel_n & chip_en_n;
   assign do_wr  = access & ~wr_n;
   assign do_rd  = access &  wr_n;
   assign idx    = addr[IDX_W-1:0];
   assign rel    = wdata[0];

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_dec
         assign we_vec[g] = do_wr & (idx == IDX_W'(g));
      end
      if (ADDR_W > IDX_W) begin : g_addr_hi
         logic unused_addr_hi;
         assign unused_addr_hi = ^addr[ADDR_W-1:IDX_W];
      end
      if (DATA_W > 1) begin : g_data_hi
         logic unused_data_hi;
         assign unused_data_hi = ^wdata[DATA_W-1:1];
      end
   endgenerate

   // Port-relative view replicated on every line, held between reads.
   always_ff @(posedge clk) begin
      if (rst)        rdata <= '1;
      else if (do_rd) rdata <= {DATA_W{~held_vec[idx]}};
   end

endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_SEM    = 8,
   parameter int ADDR_W     = 12,
   parameter int DATA_W     = 9,
   parameter bit LEFT_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              l_tok_sel_n,
   input  logic              l_chip_en_n,
   input  logic              l_wr_n,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_tok_sel_n,
   input  logic              r_chip_en_n,
   input  logic              r_wr_n,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);

   localparam int IDX_W = $clog2(NUM_SEM);

   initial begin : p_param_chk
      assert (NUM_SEM >= 2 && (NUM_SEM & (NUM_SEM - 1)) == 0)
         else $error("sem_bank: NUM_SEM must be a power of two, at least 2");
      assert (ADDR_W >= IDX_W)
         else $error("sem_bank: ADDR_W too narrow for NUM_SEM");
      assert (DATA_W >= 1)
         else $error("sem_bank: DATA_W must be positive");
   end

   logic [NUM_SEM-1:0] l_we;
   logic [NUM_SEM-1:0] r_we;
   logic [NUM_SEM-1:0] l_held;
   logic [NUM_SEM-1:0] r_held;
   logic               l_rel;
   logic               r_rel;

   sem_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_l (
      .clk       (clk),
      .rst       (rst),
      .tok_sel_n (l_tok_sel_n),
      .chip_en_n (l_chip_en_n),
      .wr_n      (l_wr_n),
      .addr      (l_addr),
      .wdata     (l_wdata),
      .held_vec  (l_held),
      .we_vec    (l_we),
      .rel       (l_rel),
      .rdata     (l_rdata)
   );

   sem_port #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port_r (
      .clk       (clk),
      .rst       (rst),
      .tok_sel_n (r_tok_sel_n),
      .chip_en_n (r_chip_en_n),
      .wr_n      (r_wr_n),
      .addr      (r_addr),
      .wdata     (r_wdata),
      .held_vec  (r_held),
      .we_vec    (r_we),
      .rel       (r_rel),
      .rdata     (r_rdata)
   );

   generate
      for (genvar g = 0; g < NUM_SEM; g++) begin : g_cell
         sem_cell #(.LEFT_FIRST(LEFT_FIRST)) u_cell (
            .clk    (clk),
            .rst    (rst),
            .l_we   (l_we[g]),
            .l_rel  (l_rel),
            .r_we   (r_we[g]),
            .r_rel  (r_rel),
            .l_held (l_held[g]),
            .r_held (r_held[g])
         );
      end
   endgenerate

endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
   parameter int NUM_SEM = 8,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 9
) (
   input logic               clk,
   input logic               rst,
   input logic               l_tok_sel_n,
   input logic               l_chip_en_n,
   input logic               l_wr_n,
   input logic [ADDR_W-1:0]  l_addr,
   input logic [DATA_W-1:0]  l_wdata,
   input logic [DATA_W-1:0]  l_rdata,
   input logic               r_tok_sel_n,
   input logic               r_chip_en_n,
   input logic               r_wr_n,
   input logic [ADDR_W-1:0]  r_addr,
   input logic [DATA_W-1:0]  r_rdata,
   input logic [NUM_SEM-1:0] l_held,
   input logic [NUM_SEM-1:0] r_held
);

   localparam int IDX_W = $clog2(NUM_SEM);

   logic             l_rd, r_rd, l_wr_ok, r_wr_ok, l_bad;
   logic [IDX_W-1:0] l_idx, r_idx;

   assign l_rd    = ~l_tok_sel_n &  l_chip_en_n &  l_wr_n;
   assign r_rd    = ~r_tok_sel_n &  r_chip_en_n &  r_wr_n;
   assign l_wr_ok = ~l_tok_sel_n &  l_chip_en_n & ~l_wr_n;
   assign r_wr_ok = ~r_tok_sel_n &  r_chip_en_n & ~r_wr_n;
   assign l_bad   = ~l_tok_sel_n & ~l_chip_en_n;
   assign l_idx   = l_addr[IDX_W-1:0];
   assign r_idx   = r_addr[IDX_W-1:0];

   AST_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
      (l_held & r_held) == '0); // R4

   AST_L_WORD_UNIFORM: assert property (@(posedge clk) disable iff (rst)
      (l_rdata == '0) || (l_rdata == '1)); // R7

   AST_R_WORD_UNIFORM: assert property (@(posedge clk) disable iff (rst)
      (r_rdata == '0) || (r_rdata == '1)); // R7

   AST_L_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !l_rd |=> $stable(l_rdata)); // R8

   AST_R_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !r_rd |=> $stable(r_rdata)); // R8

   AST_L_READ_VIEW: assert property (@(posedge clk) disable iff (rst)
      l_rd |=> (l_rdata[0] == !$past(l_held[l_idx]))); // R8

   AST_ILLEGAL_INERT: assert property (@(posedge clk) disable iff (rst)
      (l_bad && r_tok_sel_n) |=> ($stable(l_held) && $stable(r_held))); // R2

   AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
      (l_wr_ok && l_wdata[0] && l_held[l_idx]) |=> !l_held[$past(l_idx)]); // R5

   AST_NO_STEAL: assert property (@(posedge clk) disable iff (rst)
      (l_wr_ok && !l_wdata[0] && r_held[l_idx] && !(r_wr_ok && r_idx == l_idx))
      |=> r_held[$past(l_idx)]); // R4

   AST_RESET_FREE: assert property (@(posedge clk)
      rst |=> (l_held == '0 && r_held == '0)); // R10

endmodule

bind sem_bank sem_bank_chk #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .l_tok_sel_n (l_tok_sel_n),
   .l_chip_en_n (l_chip_en_n),
   .l_wr_n      (l_wr_n),
   .l_addr      (l_addr),
   .l_wdata     (l_wdata),
   .l_rdata     (l_rdata),
   .r_tok_sel_n (r_tok_sel_n),
   .r_chip_en_n (r_chip_en_n),
   .r_wr_n      (r_wr_n),
   .r_addr      (r_addr),
   .r_rdata     (r_rdata),
   .l_held      (l_held),
   .r_held      (r_held)
);

// File: tb/test_sem_bank.sv
`timescale 1ns/1ps
module test_sem_bank;
   localparam int NS = 8;
   localparam int AW = 12;
   localparam int DW = 9;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst;
   logic          l_sel_n, l_ce_n, l_wr_n, r_sel_n, r_ce_n, r_wr_n;
   logic [AW-1:0] l_addr, r_addr;
   logic [DW-1:0] l_wdata, r_wdata, l_rdata, r_rdata;

   sem_bank #(.NUM_SEM(NS), .ADDR_W(AW), .DATA_W(DW)) i_sem_bank (
      .clk(clk), .rst(rst),
      .l_tok_sel_n(l_sel_n), .l_chip_en_n(l_ce_n), .l_wr_n(l_wr_n),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_tok_sel_n(r_sel_n), .r_chip_en_n(r_ce_n), .r_wr_n(r_wr_n),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
   );

   int checks = 0;
   int fails  = 0;
   int own [NS];   // 0 free, 1 left, 2 right
   bit wt  [NS];   // waiting request from the non-holder
   logic [DW-1:0] exp_l, exp_r;
   logic [31:0]   junk = 32'h5A3C_96E1;

   // Port modes: 0 idle, 1 read, 2 write, 3 illegal (select and enable both low)
   localparam int M_IDLE = 0, M_RD = 1, M_WR = 2, M_BAD = 3;

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] view(int i, int p);
      return (own[i] == p) ? '0 : '1;
   endfunction

   function automatic void mwrite(int i, int p, bit rel);
      if (own[i] == p) begin
         if (rel) begin
            own[i] = wt[i] ? 3 - p : 0;
            wt[i]  = 1'b0;
         end
      end else if (own[i] != 0) begin
         wt[i] = !rel;
      end else if (!rel) begin
         own[i] = p;
         wt[i]  = 1'b0;
      end
   endfunction

   task automatic drive(int m, int i, bit v, output logic sn, output logic cn,
                        output logic wn, output logic [AW-1:0] a, output logic [DW-1:0] d);
      junk = junk * 32'd1103515245 + 32'd12345;
      sn = (m == M_IDLE);
      cn = (m != M_BAD);
      wn = (m == M_RD);
      a  = {junk[30:22], 3'(i)};
      d  = {junk[17:10], v};
   endtask

   // One cycle of traffic, then compare both read registers.
   task automatic step(string tag, int lm, int li, bit lv, int rm, int ri, bit rv);
      if (lm == M_RD) exp_l = view(li, 1);
      if (rm == M_RD) exp_r = view(ri, 2);
      if (lm == M_WR) mwrite(li, 1, lv);
      if (rm == M_WR) mwrite(ri, 2, rv);
      drive(lm, li, lv, l_sel_n, l_ce_n, l_wr_n, l_addr, l_wdata);
      drive(rm, ri, rv, r_sel_n, r_ce_n, r_wr_n, r_addr, r_wdata);
      @(posedge clk);
      @(negedge clk);
      chk({tag, " left"},  l_rdata, exp_l);
      chk({tag, " right"}, r_rdata, exp_r);
   endtask

   task automatic rd(string tag, int i);
      step(tag, M_RD, i, 1'b0, M_RD, i, 1'b0);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      l_sel_n = 1'b1; r_sel_n = 1'b1;
      l_ce_n = 1'b1; r_ce_n = 1'b1; l_wr_n = 1'b1; r_wr_n = 1'b1;
      l_addr = '0; r_addr = '0; l_wdata = '0; r_wdata = '0;
      for (int i = 0; i < NS; i++) begin own[i] = 0; wt[i] = 1'b0; end
      exp_l = '1; exp_r = '1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      chk("R10 reset left",  l_rdata, '1);
      chk("R10 reset right", r_rdata, '1);
   endtask

   initial begin
      #1_000_000;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      rd("R3 free", 5);
      step("R3 left takes", M_WR, 5, 1'b0, M_IDLE, 0, 1'b0);
      rd("R3 left holds", 5);
      step("R4 right denied", M_IDLE, 0, 1'b0, M_WR, 5, 1'b0);
      rd("R4 holder kept", 5);
      step("R12 holder rewrites 0", M_WR, 5, 1'b0, M_IDLE, 0, 1'b0);
      rd("R12 no change", 5);
      step("R5 left releases", M_WR, 5, 1'b1, M_IDLE, 0, 1'b0);
      rd("R5 handover to right", 5);
      step("R4 left waits", M_WR, 5, 1'b0, M_IDLE, 0, 1'b0);
      step("R5 right releases", M_IDLE, 0, 1'b0, M_WR, 5, 1'b1);
      rd("R5 handover to left", 5);
      step("R3 left frees", M_WR, 5, 1'b1, M_IDLE, 0, 1'b0);
      rd("R3 free again", 5);
      // withdrawal of a waiting request
      step("R6 left takes", M_WR, 1, 1'b0, M_IDLE, 0, 1'b0);
      step("R6 right waits", M_IDLE, 0, 1'b0, M_WR, 1, 1'b0);
      step("R6 right withdraws", M_IDLE, 0, 1'b0, M_WR, 1, 1'b1);
      step("R6 left releases", M_WR, 1, 1'b1, M_IDLE, 0, 1'b0);
      rd("R6 left free after withdraw", 1);
      // same-cycle tie
      step("R9 both request", M_WR, 3, 1'b0, M_WR, 3, 1'b0);
      rd("R9 left wins", 3);
      step("R9 left releases", M_WR, 3, 1'b1, M_IDLE, 0, 1'b0);
      rd("R9 right pending granted", 3);
      // illegal and unselected writes
      step("R2 illegal write", M_BAD, 2, 1'b0, M_IDLE, 0, 1'b0);
      rd("R2 illegal no effect", 2);
      l_sel_n = 1'b1; l_ce_n = 1'b1; l_wr_n = 1'b0; l_addr = 12'h002; l_wdata = '0;
      @(posedge clk); @(negedge clk);
      rd("R2 unselected no effect", 2);
      step("R2 illegal read holds", M_BAD, 3, 1'b1, M_IDLE, 0, 1'b0);
      // upper bits ignored
      step("R1 take idx 6", M_WR, 6, 1'b0, M_IDLE, 0, 1'b0);
      rd("R1 idx 6 held", 6);
      rd("R1 idx 7 free", 7);
      l_sel_n = 1'b0; l_ce_n = 1'b1; l_wr_n = 1'b0;
      l_addr = 12'hFF7; l_wdata = 9'h1FE;
      mwrite(7, 1, 1'b0);
      @(posedge clk); @(negedge clk);
      rd("R11 upper data ignored", 7);
      // read registered against same-edge write
      step("R8 left takes", M_WR, 4, 1'b0, M_IDLE, 0, 1'b0);
      step("R8 right waits", M_IDLE, 0, 1'b0, M_WR, 4, 1'b0);
      step("R8 read before handover", M_WR, 4, 1'b1, M_RD, 4, 1'b0);
      step("R8 right holds after", M_IDLE, 0, 1'b0, M_IDLE, 0, 1'b0);
      rd("R8 new view", 4);
      // sweep of mixed traffic on both ports
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] h;
         h = (32'(n) * 32'h9E37_79B1) ^ (32'(n) >> 3);
         if (n == 2000) do_reset();
         step("R7 sweep", int'(h[1:0]), int'(h[4:2]), h[5],
              int'(h[7:6]), int'(h[10:8]), h[11]);
      end
      for (int i = 0; i < NS; i++) rd("R7 final", i);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule